// File: doc/BRIEF.md
# I2C Control Register

This block holds the software-visible control byte of an I2C controller that can act as bus master or as slave, together with the logic that sets and clears each bit. Software writes and reads the byte over a simple bus port. The protocol engine supplies event strobes and flags: start condition sent, stop condition sent, the start-bit, byte-done and address-matched flags, the current master/slave role, and each received address byte. From the stored bits the block drives the engine's controls. These are enable, general-call enable, start request, stop request, acknowledge enable and interrupt enable. It also drives a request to hold SCL low, an interrupt line and a general-call match strobe.

The block enables in two steps. The first write with the enable bit set only switches the block on, and a second write loads the other bits. While the block is disabled, every control bit except the stop request reads as zero and every output to the engine is released. The start request clears itself when the engine reports the start condition sent. The stop request clears itself only in master mode.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset the register reads 00h. Read data is {2'b00, PE, GC_EN, STA, ACK, STO, IRQ_EN} with PE at bit 5 and IRQ_EN at bit 0. Reading has no side effects.
- R2: Bits 7:6 always read 0, and writing 1 to them changes nothing.
- R3: While PE is 0, GC_EN, STA, ACK and IRQ_EN read 0. STO keeps its stored value and still reads back. stop_req, start_req, ack_en, scl_hold, irq and gc_hit are all 0.
- R4: A write with bit 5 set while PE is 0 sets only PE. A write with bit 5 clear while PE is 0 changes nothing.
- R5: A write while PE is 1 loads bits 5:0 from the data. If bit 5 is 0, the write disables the block and loads STO from bit 1.
- R6: gc_hit is 1 in a cycle where addr_valid is 1, addr_byte is 00h, and both PE and GC_EN are 1. An address of 01h never produces gc_hit.
- R7: STA clears on the clock edge that samples start_sent. If IRQ_EN is 1, irq is 1 during that start_sent cycle.
- R8: In master mode (is_master=1), STO clears on the edge that samples stop_sent. In slave mode, stop_sent leaves STO set.
- R9: scl_hold is 1 exactly when PE is 1 and at least one of flag_sb, flag_btf or flag_addr is 1.
- R10: irq is IRQ_EN AND (flag_sb OR flag_btf OR flag_addr OR start_sent). It is 0 whenever IRQ_EN is 0.
- R11: When a bus write and a hardware clear hit STA or STO in the same cycle, the bit ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| start_sent | input | 1 | Engine sent a start condition (pulse) |
| stop_sent | input | 1 | Engine sent a stop condition (pulse) |
| is_master | input | 1 | 1 when the engine is bus master |
| flag_sb | input | 1 | Start-bit flag from the status logic |
| flag_btf | input | 1 | Byte-transfer-finished flag |
| flag_addr | input | 1 | Address-matched flag |
| addr_valid | input | 1 | addr_byte holds a received address byte |
| addr_byte | input | 8 | Received address byte |
| pe | output | 1 | Peripheral enable |
| gc_en | output | 1 | General-call enable |
| start_req | output | 1 | Start generation request |
| stop_req | output | 1 | Stop / release request, gated by enable |
| ack_en | output | 1 | Acknowledge enable |
| irq_en | output | 1 | Interrupt enable |
| scl_hold | output | 1 | Request to hold SCL low |
| irq | output | 1 | Interrupt request |
| gc_hit | output | 1 | General-call address matched |

## Verification
The bench builds the block with its defaults: an 8-bit data bus, 8-bit addresses and a general-call address of 00h. With these settings the reserved bits 7:6 are present, and the 00h address can be set against its 01h neighbour. Directed sequences cover the two-step enable, the disable write that keeps STO, the master and slave stop handling, and a write that collides with a hardware clear. A long stretch of random writes, flags and role changes then follows, and a behavioural model is compared against every output on every cycle.

// File: rtl/i2c_ctl_pkg.sv
// Shared definitions for the I2C control register.
// Bit positions are fixed by software and must not move.
package i2c_ctl_pkg;
    localparam int NUM_CTL   = 6;
    localparam int BIT_IRQEN = 0;
    localparam int BIT_STO   = 1;
    localparam int BIT_ACK   = 2;
    localparam int BIT_STA   = 3;
    localparam int BIT_GCEN  = 4;
    localparam int BIT_PE    = 5;

    // Packed so that field order matches bit order (pe = bit 5 .. irq_en = bit 0)
    typedef struct packed {
        logic pe;
        logic gc_en;
        logic sta;
        logic ack;
        logic sto;
        logic irq_en;
    } ctl_t;
endpackage

// File: rtl/i2c_ctl_wrdec.sv
// Write decoder: turns a bus write into load commands.
// It assumes pe_q is the enable bit currently stored.
// A write while disabled may only raise PE. A write while enabled loads all control bits.
module i2c_ctl_wrdec
    import i2c_ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              pe_q,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              load_all,
    output logic              load_pe_only,
    output ctl_t              wr_val
);
    // Decode the write into its load kind and field value
    always_comb begin
        wr_val       = ctl_t'(wr_data[NUM_CTL-1:0]);
        load_all     = wr_en && pe_q;
        load_pe_only = wr_en && !pe_q && wr_data[BIT_PE];
    end
endmodule

// File: rtl/i2c_ctl_regbits.sv
// Control bit storage with the hardware clear rules.
// A hardware clear of STA or STO wins over a bus write in the same cycle.
// Bits other than PE and STO are stored as 0 whenever the next PE is 0.
module i2c_ctl_regbits
    import i2c_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_all,
    input  logic load_pe_only,
    input  ctl_t wr_val,
    input  logic start_sent,
    input  logic stop_sent,
    input  logic is_master,
    output ctl_t q
);
    ctl_t               nxt;
    logic [NUM_CTL-1:0] nxt_v;
    logic [NUM_CTL-1:0] q_v;

    // Next value before the enable gating is applied
    always_comb begin
        nxt = q;
        if (load_pe_only) nxt.pe = 1'b1;
        if (load_all)     nxt    = wr_val;
        if (start_sent)   nxt.sta = 1'b0;
        if (stop_sent && is_master) nxt.sto = 1'b0;
        nxt_v = nxt;
    end

    // One flop per bit; PE and STO are kept as they are, the rest are gated by the next PE
    for (genvar i = 0; i < NUM_CTL; i++) begin : g_bit
        if (i == BIT_PE || i == BIT_STO) begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n) q_v[i] <= 1'b0;
                else        q_v[i] <= nxt_v[i];
            end
        end else begin : g_gated
            always_ff @(posedge clk) begin
                if (!rst_n) q_v[i] <= 1'b0;
                else        q_v[i] <= nxt_v[i] & nxt_v[BIT_PE];
            end
        end
    end

    assign q = ctl_t'(q_v);

    // R4
    pe_first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pe_only && !(stop_sent && is_master)) |=>
            (q.pe && !q.gc_en && !q.sta && !q.ack && !q.irq_en && $stable(q.sto)));
    // R7
    sta_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_sent |=> !q.sta);
    // R8
    sto_master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_sent && is_master) |=> !q.sto);
    // R8
    sto_slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sto && !is_master && !load_all) |=> q.sto);
    // R3
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_all && !load_pe_only && !q.pe) |=> (!q.gc_en && !q.sta && !q.ack && !q.irq_en));
endmodule

// File: rtl/i2c_ctl_evout.sv
// Output stage: drives the engine controls, the SCL hold request, the interrupt and the general-call match.
// All engine-facing outputs are released while PE is 0.
module i2c_ctl_evout
    import i2c_ctl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int GC_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              q,
    input  logic              start_sent,
    input  logic              flag_sb,
    input  logic              flag_btf,
    input  logic              flag_addr,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_byte,
    output logic              start_req,
    output logic              stop_req,
    output logic              ack_en,
    output logic              scl_hold,
    output logic              irq,
    output logic              gc_hit
);
    localparam logic [ADDR_W-1:0] GC_MATCH = ADDR_W'(GC_ADDR);
    localparam logic [ADDR_W-1:0] GC_NEAR  = ADDR_W'(GC_ADDR + 1);

    logic any_flag;

    // Combine the flags, gate the controls and match the general-call address
    always_comb begin
        any_flag  = flag_sb || flag_btf || flag_addr;
        start_req = q.sta;
        ack_en    = q.ack;
        stop_req  = q.pe && q.sto;
        scl_hold  = q.pe && any_flag;
        irq       = q.irq_en && (any_flag || start_sent);
        gc_hit    = q.pe && q.gc_en && addr_valid && (addr_byte == GC_MATCH);
    end

    // R9
    hold_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pe |-> !scl_hold);
    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.irq_en |-> !irq);
    // R6
    gc_neighbour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_byte == GC_NEAR) |-> !gc_hit);
    // R3
    stop_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pe |-> (!stop_req && !gc_hit && !irq));
endmodule

// File: rtl/i2c_ctl_reg.sv
// Top of the I2C control register: write decode, bit storage and output stage.
// Reads are combinational and have no side effects.
// Assumes DATA_W >= 6 so that all control bits fit on the bus.
module i2c_ctl_reg
    import i2c_ctl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 8,
    parameter int GC_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              start_sent,
    input  logic              stop_sent,
    input  logic              is_master,
    input  logic              flag_sb,
    input  logic              flag_btf,
    input  logic              flag_addr,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_byte,
    output logic              pe,
    output logic              gc_en,
    output logic              start_req,
    output logic              stop_req,
    output logic              ack_en,
    output logic              irq_en,
    output logic              scl_hold,
    output logic              irq,
    output logic              gc_hit
);
    localparam int PAD_W = DATA_W - NUM_CTL;

    ctl_t q;
    ctl_t wr_val;
    logic load_all;
    logic load_pe_only;

    i2c_ctl_wrdec #(.DATA_W(DATA_W)) u_wrdec (
        .pe_q         (q.pe),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .load_all     (load_all),
        .load_pe_only (load_pe_only),
        .wr_val       (wr_val)
    );

    i2c_ctl_regbits u_bits (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_all     (load_all),
        .load_pe_only (load_pe_only),
        .wr_val       (wr_val),
        .start_sent   (start_sent),
        .stop_sent    (stop_sent),
        .is_master    (is_master),
        .q            (q)
    );

    i2c_ctl_evout #(.ADDR_W(ADDR_W), .GC_ADDR(GC_ADDR)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .q          (q),
        .start_sent (start_sent),
        .flag_sb    (flag_sb),
        .flag_btf   (flag_btf),
        .flag_addr  (flag_addr),
        .addr_valid (addr_valid),
        .addr_byte  (addr_byte),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .ack_en     (ack_en),
        .scl_hold   (scl_hold),
        .irq        (irq),
        .gc_hit     (gc_hit)
    );

    // Read view with the reserved bits tied low, plus the plain bit outputs
    always_comb begin
        rd_data = {{PAD_W{1'b0}}, q};
        pe      = q.pe;
        gc_en   = q.gc_en;
        irq_en  = q.irq_en;
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:NUM_CTL] == '0);
    // R11
    hw_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && start_sent) |=> !start_req);
endmodule

// File: tb/i2c_ctl_reg_test.sv
// Bench: directed sequences followed by random traffic. A behavioural model is checked on every clock.
module i2c_ctl_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       start_sent = 1'b0, stop_sent = 1'b0, is_master = 1'b0;
    logic       flag_sb = 1'b0, flag_btf = 1'b0, flag_addr = 1'b0;
    logic       addr_valid = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       pe, gc_en, start_req, stop_req, ack_en, irq_en, scl_hold, irq, gc_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] m_cr = 8'h00;   // model of the register

    always #4 clk = ~clk;       // 125 MHz

    i2c_ctl_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .start_sent(start_sent), .stop_sent(stop_sent), .is_master(is_master),
        .flag_sb(flag_sb), .flag_btf(flag_btf), .flag_addr(flag_addr),
        .addr_valid(addr_valid), .addr_byte(addr_byte),
        .pe(pe), .gc_en(gc_en), .start_req(start_req), .stop_req(stop_req),
        .ack_en(ack_en), .irq_en(irq_en), .scl_hold(scl_hold), .irq(irq), .gc_hit(gc_hit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Compare every output with the model and the current inputs
    task automatic compare();
        logic mpe, flags;
        mpe   = m_cr[5];
        flags = flag_sb | flag_btf | flag_addr;
        chk("R1 rd_data", rd_data, m_cr);
        chk("R5 pe", pe, mpe);
        chk("R5 gc_en", gc_en, m_cr[4]);
        chk("R7 start_req", start_req, m_cr[3]);
        chk("R5 ack_en", ack_en, m_cr[2]);
        chk("R8 stop_req", stop_req, mpe & m_cr[1]);
        chk("R5 irq_en", irq_en, m_cr[0]);
        chk("R9 scl_hold", scl_hold, mpe & flags);
        chk("R10 irq", irq, m_cr[0] & (flags | start_sent));
        chk("R6 gc_hit", gc_hit, mpe & m_cr[4] & addr_valid & (addr_byte == 8'h00));
    endtask

    // Advance the model using the inputs held over this edge
    task automatic model_update();
        if (!rst_n) m_cr = 8'h00;
        else begin
            if (wr_en) begin
                if (!m_cr[5]) begin
                    if (wr_data[5]) m_cr[5] = 1'b1;
                end else begin
                    m_cr = wr_data & 8'h3F;
                end
            end
            if (start_sent) m_cr[3] = 1'b0;
            if (stop_sent && is_master) m_cr[1] = 1'b0;
            if (!m_cr[5]) m_cr = m_cr & 8'h22;
        end
    endtask

    task automatic tick();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 0; start_sent = 0; stop_sent = 0;
        flag_sb = 0; flag_btf = 0; flag_addr = 0; addr_valid = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; tick(); wr_en = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset value", rd_data, 8'h00);

        // R4: the first enable write raises only PE
        wr(8'h3F); tick();
        chk("R4 first enable", rd_data, 8'h20);
        // R5: the second write loads everything; R2: bits 7:6 stay 0
        wr(8'hFF); tick();
        chk("R2 reserved ignored", rd_data, 8'h3F);
        // R8: in slave mode stop_sent leaves STO set
        is_master = 0; stop_sent = 1; tick(); stop_sent = 0; tick();
        chk("R8 slave keeps STO", rd_data[1], 1);
        // R7: start_sent raises irq in the same cycle, STA clears
        start_sent = 1; #1 chk("R7 irq on start", irq, 1); tick(); start_sent = 0; tick();
        chk("R7 STA cleared", rd_data[3], 0);
        // R6: general call at 00h matches, 01h does not
        addr_valid = 1; addr_byte = 8'h00; #1 chk("R6 gc 00h", gc_hit, 1); tick();
        addr_byte = 8'h01; #1 chk("R6 gc 01h", gc_hit, 0); tick(); addr_valid = 0;
        // R9: a flag requests SCL hold
        flag_btf = 1; #1 chk("R9 hold on btf", scl_hold, 1); tick(); flag_btf = 0;
        // R8: master mode clears STO on stop_sent
        is_master = 1; stop_sent = 1; tick(); stop_sent = 0; tick();
        chk("R8 master clears STO", rd_data[1], 0);
        // R11: a write of STA collides with start_sent
        wr_en = 1; wr_data = 8'h2D; start_sent = 1; tick(); quiet(); tick();
        chk("R11 hw clear wins", rd_data, 8'h25);
        // R3: a disable write keeps STO and releases the outputs
        wr(8'h02); tick();
        chk("R3 disable keeps STO", rd_data, 8'h02);
        flag_sb = 1; #1 chk("R3 outputs released", {stop_req, scl_hold, irq}, 3'b000); tick(); flag_sb = 0;
        // R4: a write with PE clear while disabled does nothing
        wr(8'h1D); tick();
        chk("R4 disabled write ignored", rd_data, 8'h02);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            wr_en      = ($urandom_range(0, 5) == 0);
            wr_data    = 8'($urandom);
            start_sent = ($urandom_range(0, 7) == 0);
            stop_sent  = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) is_master = ~is_master;
            flag_sb    = ($urandom_range(0, 3) == 0);
            flag_btf   = ($urandom_range(0, 3) == 0);
            flag_addr  = ($urandom_range(0, 3) == 0);
            addr_valid = ($urandom_range(0, 2) == 0);
            addr_byte  = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 1)) : 8'($urandom);
            tick();
        end
        quiet();
        tick();
        finish_run();
    end
endmodule